// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block sits between a simple host bus and the command pins of an SDRAM device. Software drives the device through its power-up sequence with it. Software writes a three-bit operating mode into a control register. The block then holds the device in continuous NOP, sends a precharge to every bank, loads mode registers, or runs in normal mode. A programmable interval timer runs alongside these modes and inserts auto-refresh commands.

In the mode-register phase, the mode word does not come from a data register. It comes from the address of a host read into the memory window. The bank-select bits of that address choose the target bank, and the low address bits are driven onto the SDRAM address bus as the mode value. In the precharge phase, a host write into a bank region makes the block precharge that bank. Software uses these writes as a fallback in case the precharge-all command was lost. The long power-up wait before the first command is left to software.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, the block drives CKE low, drives a NOP command (cs_n=0, ras_n=1, cas_n=1, we_n=1) with bank and address zero, and holds hb_ready high.
- R2: The mode register is the register access at hb_addr[0]=0. Its bits are bit0=CKE, bit1=MRS and bit2=INIT. With value 3'b111, every cycle carries NOP with CKE high. Memory accesses are accepted but issue nothing, and no refresh is issued.
- R3: Writing mode 3'b101 issues one PRECHARGE ALL (ras_n=0, cas_n=1, we_n=0, a[10]=1, bank 0) in the cycle after the write is accepted, unless a refresh is owed.
- R4: In mode 3'b101, a host memory write issues a PRECHARGE (a[10]=0) to the bank given by hb_addr[ROW_W+1:ROW_W], on the edge that accepts the write. Memory reads issue nothing.
- R5: In mode 3'b011, a host memory read issues a MODE REGISTER SET (all four command pins low) on the edge that accepts it. Its bank comes from hb_addr[ROW_W+1:ROW_W], and sd_a carries hb_addr[ROW_W-1:0]. Memory writes issue nothing.
- R6: In mode 3'b001 (normal), host memory accesses issue no command. Refreshes continue.
- R7: The register at hb_addr[0]=1 sets the refresh interval N. With N>0, and with CKE set outside the NOP mode, one AUTO REFRESH (ras_n=0, cas_n=0, we_n=1) falls due every N clocks. The first falls due N clocks after the write. N=0 stops all refreshes.
- R8: Every command lasts one clock. At least GAP_CYC NOP cycles follow it, and hb_ready stays low during those cycles.
- R9: A refresh that falls due while a command's gap is running, or while one is pending, is kept and issued on the first idle cycle. Pending refreshes go out before a pending precharge-all or host command, and none is lost.
- R10: With mode bit0 clear, CKE is low, only NOP is driven, and accesses issue nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_valid | input | 1 | Host access request |
| hb_write | input | 1 | 1 for write, 0 for read |
| hb_reg | input | 1 | 1 selects the registers, 0 the memory window |
| hb_addr | input | ROW_W+2 | Bank select in the top two bits, row/mode value below; bit0 picks the register |
| hb_wdata | input | RF_W | Register write data |
| hb_ready | output | 1 | Access is taken on a clock edge where hb_valid and hb_ready are both high |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | ROW_W | Address bus (mode value, a[10] precharge-all flag) |

## Verification
The bench uses ROW_W=13, RF_W=16 and GAP_CYC=2. With these values, refresh intervals of 10 and 4 clocks can be compared against the three-cycle command spacing. An interval of 4 makes refreshes fall due inside the gaps of back-to-back precharges, so the pending path and its priority over host commands are exercised. The 520-clock interval runs across the mode-register phase, and an interval of 0 must silence refresh over a long window.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int ROW_W   = 13,
  parameter int RF_W    = 16,
  parameter int GAP_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hb_valid,
  input  logic             hb_write,
  input  logic             hb_reg,
  input  logic [ROW_W+1:0] hb_addr,
  input  logic [RF_W-1:0]  hb_wdata,
  output logic             hb_ready,
  output logic             sd_cke,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [1:0]       sd_ba,
  output logic [ROW_W-1:0] sd_a
);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam int PW = 4;
  localparam int AP = 10;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [2:0] M_NOP  = 3'b111;
  localparam logic [2:0] M_PALL = 3'b101;
  localparam logic [2:0] M_MRS  = 3'b011;
  localparam logic [GW-1:0] GAP_LD = GW'(GAP_CYC);

  logic [2:0]       mode_q;
  logic [RF_W-1:0]  rf_int_q, rf_cnt_q;
  logic [PW-1:0]    pend_q, pend_d;
  logic             pall_q, pall_go, ref_go;
  logic [GW-1:0]    gap_q;
  logic [3:0]       cmd_q, cmd_d;
  logic [1:0]       ba_q, ba_d;
  logic [ROW_W-1:0] a_q, a_d;
  logic [1:0]       bank;
  logic             ref_ok, due, idle, acc, wr_mode, wr_int;

  assign bank     = hb_addr[ROW_W+1:ROW_W];
  assign ref_ok   = mode_q[0] && (mode_q != M_NOP);
  assign due      = ref_ok && (rf_int_q != '0) && (rf_cnt_q == RF_W'(1));
  assign idle     = (gap_q == '0);
  assign hb_ready = idle && (pend_q == '0) && !due && !pall_q;
  assign acc      = hb_valid && hb_ready;
  assign wr_mode  = acc && hb_reg && hb_write && !hb_addr[0];
  assign wr_int   = acc && hb_reg && hb_write && hb_addr[0];

  always_comb begin
    cmd_d   = C_NOP;
    ba_d    = '0;
    a_d     = '0;
    ref_go  = 1'b0;
    pall_go = 1'b0;
    if (idle) begin
      if (ref_ok && (due || pend_q != '0)) begin
        cmd_d  = C_REF;
        ref_go = 1'b1;
      end else if (pall_q) begin
        cmd_d   = C_PRE;
        a_d[AP] = 1'b1;
        pall_go = 1'b1;
      end else if (acc && !hb_reg) begin
        if (hb_write && mode_q == M_PALL) begin
          cmd_d = C_PRE;
          ba_d  = bank;
        end else if (!hb_write && mode_q == M_MRS) begin
          cmd_d = C_MRS;
          ba_d  = bank;
          a_d   = hb_addr[ROW_W-1:0];
        end
      end
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (!ref_ok)
      pend_d = '0;
    else if (ref_go) begin
      if (!due) pend_d = pend_q - PW'(1);
    end else if (due && pend_q != '1)
      pend_d = pend_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      rf_int_q <= '0;
      rf_cnt_q <= '0;
      pend_q   <= '0;
      pall_q   <= 1'b0;
      gap_q    <= '0;
      cmd_q    <= C_NOP;
      ba_q     <= '0;
      a_q      <= '0;
    end else begin
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      a_q    <= a_d;
      pend_q <= pend_d;
      if (cmd_d != C_NOP)
        gap_q <= GAP_LD;
      else if (!idle)
        gap_q <= gap_q - GW'(1);
      if (wr_mode) begin
        mode_q <= hb_wdata[2:0];
        pall_q <= (hb_wdata[2:0] == M_PALL);
      end else if (pall_go)
        pall_q <= 1'b0;
      if (wr_int) begin
        rf_int_q <= hb_wdata;
        rf_cnt_q <= hb_wdata;
      end else if (ref_ok && rf_int_q != '0)
        rf_cnt_q <= (rf_cnt_q == RF_W'(1)) ? rf_int_q : rf_cnt_q - RF_W'(1);
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_cke = mode_q[0];
  assign sd_ba  = ba_q;
  assign sd_a   = a_q;
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int ROW_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hb_valid,
  input logic             hb_write,
  input logic             hb_reg,
  input logic [ROW_W+1:0] hb_addr,
  input logic             hb_ready,
  input logic             sd_cke,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [1:0]       sd_ba,
  input logic [ROW_W-1:0] sd_a,
  input logic [2:0]       mode_q
);
  logic [3:0] cmd;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  a_r8_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 4'b0111) |=> (cmd == 4'b0111));

  a_r8_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 4'b0111) |-> !hb_ready);

  a_r2_nop_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b111) |-> (cmd == 4'b0111 && sd_cke));

  a_r10_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cke |-> (cmd == 4'b0111));

  a_r3_pall_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010 && sd_a[10]) |-> (mode_q == 3'b101 && sd_ba == 2'b00));

  a_r4_bank_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010 && !sd_a[10]) |->
      ($past(hb_valid && hb_ready && hb_write && !hb_reg)
       && sd_ba == $past(hb_addr[ROW_W+1:ROW_W])));

  a_r5_mrs_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0000) |->
      ($past(hb_valid && hb_ready && !hb_write && !hb_reg)
       && sd_a == $past(hb_addr[ROW_W-1:0])
       && sd_ba == $past(hb_addr[ROW_W+1:ROW_W])));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ROW_W(ROW_W)) u_chk (.*);

// File: tb/sim_sdram_init_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_seq;
  localparam int ROW_W = 13;
  localparam int RF_W  = 16;
  localparam int GAP   = 2;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 0, rst_n = 0;
  logic hb_valid = 0, hb_write = 0, hb_reg = 0;
  logic [ROW_W+1:0] hb_addr = '0;
  logic [RF_W-1:0] hb_wdata = '0;
  logic hb_ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba;
  logic [ROW_W-1:0] sd_a;

  always #10 clk = ~clk;

  sdram_init_seq #(.ROW_W(ROW_W), .RF_W(RF_W), .GAP_CYC(GAP)) u0 (.*);

  int n_chk = 0, n_fail = 0, cyc = 0, nref = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_mode, m_int, m_cnt, m_pend, m_gap;
  bit m_pall;
  logic [3:0] e_cmd;
  logic [1:0] e_ba;
  logic [ROW_W-1:0] e_a;

  function automatic bit m_ok();
    return (m_mode % 2 == 1) && m_mode != 7;
  endfunction
  function automatic bit m_due();
    return m_ok() && m_int != 0 && m_cnt == 1;
  endfunction
  function automatic bit m_ready();
    return m_gap == 0 && m_pend == 0 && !m_due() && !m_pall;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_int = 0; m_cnt = 0; m_pend = 0; m_gap = 0; m_pall = 0;
      e_cmd = NOP; e_ba = '0; e_a = '0;
    end else begin
      bit ok, d, acc;
      ok = m_ok(); d = m_due(); acc = hb_valid && m_ready();
      e_cmd = NOP; e_ba = '0; e_a = '0;
      if (m_gap > 0) begin
        m_gap--;
        if (d) m_pend++;
      end else if (ok && (d || m_pend > 0)) begin
        e_cmd = REF; m_gap = GAP;
        if (!d) m_pend--;
      end else if (m_pall) begin
        e_cmd = PRE; e_a[10] = 1'b1; m_pall = 0; m_gap = GAP;
      end else if (acc && !hb_reg && hb_write && m_mode == 5) begin
        e_cmd = PRE; e_ba = hb_addr[ROW_W+1:ROW_W]; m_gap = GAP;
      end else if (acc && !hb_reg && !hb_write && m_mode == 3) begin
        e_cmd = MRS; e_ba = hb_addr[ROW_W+1:ROW_W]; e_a = hb_addr[ROW_W-1:0]; m_gap = GAP;
      end
      if (!ok) m_pend = 0;
      if (acc && hb_reg && hb_write && hb_addr[0]) begin
        m_int = int'(hb_wdata); m_cnt = m_int;
      end else if (ok && m_int != 0)
        m_cnt = (m_cnt == 1) ? m_int : m_cnt - 1;
      if (acc && hb_reg && hb_write && !hb_addr[0]) begin
        m_mode = int'(hb_wdata[2:0]); m_pall = (m_mode == 5);
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      logic [3:0] c;
      string tag;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (c == REF) nref++;
      case (e_cmd)
        REF: tag = "R9";
        MRS: tag = "R5";
        PRE: tag = e_a[10] ? "R3" : "R4";
        default: tag = (m_mode == 7) ? "R2" : (m_mode % 2 == 0) ? "R10" : "R8";
      endcase
      check({c, sd_ba, sd_a} == {e_cmd, e_ba, e_a}, tag, "cmd/ba/a",
            longint'({c, sd_ba, sd_a}), longint'({e_cmd, e_ba, e_a}));
      check(sd_cke == (m_mode % 2 == 1), "R10", "cke", longint'(sd_cke), longint'(m_mode % 2));
      check(hb_ready == m_ready(), "R8", "hb_ready", longint'(hb_ready), longint'(m_ready()));
    end
  end

  task automatic host(input bit r, input bit w, input logic [ROW_W+1:0] ad, input int d);
    @(negedge clk);
    hb_valid = 1; hb_reg = r; hb_write = w; hb_addr = ad; hb_wdata = RF_W'(d);
    while (!hb_ready) @(negedge clk);
    @(negedge clk);
    hb_valid = 0;
    #1;
  endtask

  function automatic logic [ROW_W+1:0] ma(input int b, input int low);
    return {2'(b), ROW_W'(low)};
  endfunction

  function automatic logic [3:0] cmd_now();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  task automatic expect_cmd(input string req, input logic [3:0] c, input logic [1:0] b,
                            input logic [ROW_W-1:0] a);
    check({cmd_now(), sd_ba, sd_a} == {c, b, a}, req, "command",
          longint'({cmd_now(), sd_ba, sd_a}), longint'({c, b, a}));
  endtask

  initial begin
    int c0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(!sd_cke && cmd_now() == NOP && sd_a == '0 && sd_ba == '0, "R1", "reset outputs",
          longint'({sd_cke, cmd_now()}), longint'({1'b0, NOP}));
    check(hb_ready, "R1", "ready after reset", longint'(hb_ready), 1);

    host(1, 1, 0, 7);
    check(sd_cke, "R2", "cke in nop mode", longint'(sd_cke), 1);
    host(0, 1, ma(1, 5), 0);
    expect_cmd("R2", NOP, 0, 0);
    host(0, 0, ma(2, 9), 0);
    expect_cmd("R2", NOP, 0, 0);

    host(1, 1, 0, 5);
    @(negedge clk); #1;
    expect_cmd("R3", PRE, 0, ROW_W'(1 << 10));
    for (int b = 0; b < 4; b++) begin
      host(0, 1, ma(b, 3), 0);
      expect_cmd("R4", PRE, 2'(b), '0);
      check(!hb_ready, "R8", "ready low in gap", longint'(hb_ready), 0);
      @(negedge clk); #1;
      check(cmd_now() == NOP && !hb_ready, "R8", "gap cycle",
            longint'({hb_ready, cmd_now()}), longint'({1'b0, NOP}));
    end
    host(0, 0, ma(1, 3), 0);
    expect_cmd("R4", NOP, 0, 0);

    host(1, 1, 1, 10);
    c0 = cyc; r0 = nref;
    repeat (80) @(negedge clk);
    #1;
    check(nref - r0 == 8, "R7", "refreshes in 80 clocks", longint'(nref - r0), 8);

    host(1, 1, 1, 4);
    c0 = cyc; r0 = nref;
    for (int i = 0; i < 6; i++) host(0, 1, ma(i % 4, 0), 0);
    repeat (20) @(negedge clk);
    #1;
    check(nref - r0 == (cyc - c0) / 4, "R9", "no refresh lost",
          longint'(nref - r0), longint'((cyc - c0) / 4));

    host(1, 1, 1, 520);
    host(1, 1, 0, 3);
    for (int b = 0; b < 4; b++) begin
      host(0, 0, ma(b, 'h230 + b), 0);
      expect_cmd("R5", MRS, 2'(b), ROW_W'('h230 + b));
    end
    host(0, 1, ma(2, 'h31), 0);
    expect_cmd("R5", NOP, 0, 0);

    host(1, 1, 0, 1);
    host(0, 1, ma(3, 1), 0);
    expect_cmd("R6", NOP, 0, 0);
    host(0, 0, ma(0, 'h22), 0);
    expect_cmd("R6", NOP, 0, 0);
    c0 = cyc; r0 = nref;
    repeat (1100) @(negedge clk);
    #1;
    check(nref - r0 >= 2, "R7", "refresh at 520 interval", longint'(nref - r0), 2);

    host(1, 1, 1, 0);
    r0 = nref;
    repeat (600) @(negedge clk);
    #1;
    check(nref == r0, "R7", "interval zero disables", longint'(nref - r0), 0);

    host(1, 1, 0, 0);
    check(!sd_cke, "R10", "cke low", longint'(sd_cke), 0);
    host(0, 1, ma(1, 1), 0);
    expect_cmd("R10", NOP, 0, 0);

    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule